// File: doc/BRIEF.md
# Memory and I/O Space Decoder

This block sits on a 16-bit system bus that carries a single shared address together with separate strobes for memory requests, I/O requests, reads and writes. From these signals it produces active-high chip enables for three targets: a RAM, a device whose registers sit in the top quarter of memory space, and an I/O port device. Memory space and I/O space share the same address lines. They never collide, because memory targets respond only to the memory strobe and I/O targets respond only to the I/O strobe.

Decoding is deliberately partial. The device window is recognised from the two most significant address bits alone. In I/O space, only address bit 0 is examined. With bit 0 low the access goes to the port device, and with bit 0 high it goes to a one-bit window-select register. That register sets which target answers in the top quarter of memory. When it is clear, the device registers answer there. When it is set, the RAM hidden behind them answers instead.

If both strobes are seen together, the block treats it as a bus protocol fault. It enables nothing and raises an error flag for that cycle.

Top module: `bus_space_decoder`

## Requirements
- R1: After reset the window-select register is 0. A memory request with address bits 15 and 14 both high then enables the device and does not enable the RAM.
- R2: A memory request (memReq=1, ioReq=0) with address bits 15:14 not both 1 enables only ramCs. This holds for reads, writes and strobe-less requests.
- R3: With the window-select register at 0, any memory request with bits 15:14 = 11 enables only devCs. The other address bits have no effect.
- R4: An I/O request (ioReq=1, memReq=0) with rdStrobe=1 and address bit 0 = 0 enables only portCs. No other address bit is compared. Without rdStrobe, portCs stays low.
- R5: An I/O request never enables ramCs or devCs, whatever the address, including addresses from 0xC000 to 0xFFFF.
- R6: An I/O request with wrStrobe=1 and address bit 0 = 1 loads ctrlData into the window-select register at the next rising clock edge. With the register at 1, a memory request with bits 15:14 = 11 enables only ramCs. Writing 0 restores the device.
- R7: When memReq and ioReq are both 1 in the same cycle, ramCs, devCs and portCs are all 0 and busErr is 1. A window-select write presented in that cycle is ignored.
- R8: With neither strobe active, all chip enables and busErr are 0.
- R9: A memory write never changes the window-select register, even at an odd address.
- R10: At most one of ramCs, devCs and portCs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the window-select register |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Shared address bus |
| memReq | input | 1 | Memory-space request strobe |
| ioReq | input | 1 | I/O-space request strobe |
| rdStrobe | input | 1 | Read strobe |
| wrStrobe | input | 1 | Write strobe |
| ctrlData | input | 1 | Data bit written into the window-select register |
| ramCs | output | 1 | RAM chip enable |
| devCs | output | 1 | Memory-window device chip enable |
| portCs | output | 1 | I/O port device chip enable |
| busErr | output | 1 | Both strobes seen together this cycle |

## Verification
The hardest state to reach is the RAM answering inside the device window. Getting there takes a correctly formed I/O write to the odd port, followed by memory traffic at addresses from 0xC000 to 0xFFFF. The stimulus first writes the select bit to 1 and probes the window. It then tries to disturb the bit in two ways: a memory write at an odd address, and a select write presented during a strobe clash. It re-probes the window after each attempt. Finally it writes the bit back to 0 and confirms that the device returns.

// File: rtl/bus_space_decoder_pkg.sv
package bus_space_decoder_pkg;
  typedef struct packed {
    logic memSel;
    logic ioSel;
    logic busErr;
  } spaceStrobes_t;
endpackage

// File: rtl/space_ctrl.sv
module space_ctrl
  import bus_space_decoder_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          memReq,
  input  logic          ioReq,
  output spaceStrobes_t strobes
);
  always_comb begin
    strobes.busErr = memReq & ioReq;
    strobes.memSel = memReq & ~ioReq;
    strobes.ioSel  = ioReq & ~memReq;
  end

  assert_clash_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && ioReq) |-> (strobes.busErr && !strobes.memSel && !strobes.ioSel));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && !ioReq) |-> (strobes == '0));
endmodule

// File: rtl/space_datapath.sv
module space_datapath
  import bus_space_decoder_pkg::*;
#(
  parameter int WIN_BITS     = 2,
  parameter int PORT_SEL_BIT = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WIN_BITS-1:0] winAddr,
  input  logic                portAddrBit,
  input  logic                rdStrobe,
  input  logic                wrStrobe,
  input  logic                ctrlData,
  input  spaceStrobes_t       strobes,
  output logic                ramCs,
  output logic                devCs,
  output logic                portCs
);
  logic showRam;
  logic inWindow;
  logic selWrEn;

  assign inWindow = &winAddr;
  assign selWrEn  = strobes.ioSel & wrStrobe & portAddrBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        showRam <= 1'b0;
    else if (selWrEn) showRam <= ctrlData;
  end

  always_comb begin
    ramCs  = strobes.memSel & (~inWindow | showRam);
    devCs  = strobes.memSel & inWindow & ~showRam;
    portCs = strobes.ioSel & rdStrobe & ~portAddrBit;
  end

  assert_onehot_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramCs, devCs, portCs}));
  assert_io_no_mem_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ioSel |-> (!ramCs && !devCs));
  assert_port_needs_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    portCs |-> (rdStrobe && strobes.ioSel));
  assert_sel_change_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(showRam) |-> $past(strobes.ioSel && wrStrobe));
  assert_mem_keeps_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.memSel) |-> $stable(showRam));
endmodule

// File: rtl/bus_space_decoder.sv
module bus_space_decoder
  import bus_space_decoder_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int WIN_BITS     = 2,
  parameter int PORT_SEL_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              ctrlData,
  output logic              ramCs,
  output logic              devCs,
  output logic              portCs,
  output logic              busErr
);
  localparam int WIN_LSB = ADDR_W - WIN_BITS;

  spaceStrobes_t strobes;
  logic unusedAddrBits;

  assign unusedAddrBits = ^addr[WIN_LSB-1:PORT_SEL_BIT+1];

  space_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .memReq(memReq), .ioReq(ioReq), .strobes(strobes)
  );

  space_datapath #(.WIN_BITS(WIN_BITS), .PORT_SEL_BIT(PORT_SEL_BIT)) i_dp (
    .clk(clk), .rstN(rstN),
    .winAddr(addr[ADDR_W-1:WIN_LSB]), .portAddrBit(addr[PORT_SEL_BIT]),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .ctrlData(ctrlData),
    .strobes(strobes), .ramCs(ramCs), .devCs(devCs), .portCs(portCs)
  );

  assign busErr = strobes.busErr;

  assert_err_no_cs_R7: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (!ramCs && !devCs && !portCs));
endmodule

// File: tb/test_bus_space_decoder.sv
`timescale 1ns/1ps
module test_bus_space_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = '0;
  logic memReq = 1'b0, ioReq = 1'b0, rdStrobe = 1'b0, wrStrobe = 1'b0, ctrlData = 1'b0;
  logic ramCs, devCs, portCs, busErr;

  int total = 0;
  int bad = 0;
  bit modelShow = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];
  event go;

  always #2.5 clk = ~clk;

  bus_space_decoder i_bus_space_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .memReq(memReq), .ioReq(ioReq),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .ctrlData(ctrlData),
    .ramCs(ramCs), .devCs(devCs), .portCs(portCs), .busErr(busErr)
  );

  task automatic step(input logic [15:0] a, input logic m, input logic i,
                      input logic r, input logic w, input logic d, input string tag);
    item_t it;
    logic win;
    @(negedge clk);
    addr = a; memReq = m; ioReq = i; rdStrobe = r; wrStrobe = w; ctrlData = d;
    win = a[15] & a[14];
    it.tag = tag;
    it.exp = '0;
    if (m && i) it.exp[0] = 1'b1;
    else if (m) begin
      it.exp[3] = !win || modelShow;
      it.exp[2] = win && !modelShow;
    end else if (i) it.exp[1] = r && !a[0];
    q.push_back(it);
    -> go;
    if (i && !m && w && a[0] && rstN) modelShow = d;
  endtask

  initial begin
    forever begin
      @(go);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it = q.pop_front();
        act = {ramCs, devCs, portCs, busErr};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: {ram,dev,port,err} actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(16'hC000, 1, 0, 1, 0, 0, "R1 reset window is device");
    step(16'h0000, 0, 0, 0, 0, 0, "R8 idle in reset");
    @(negedge clk); rstN = 1'b1;
    step(16'hE001, 1, 0, 1, 0, 0, "R1 after reset device");
    step(16'h0000, 1, 0, 1, 0, 0, "R2 ram low");
    step(16'h8FFF, 1, 0, 0, 1, 0, "R2 ram write");
    step(16'h4000, 1, 0, 0, 0, 0, "R2 ram no rw");
    step(16'hFFFF, 1, 0, 1, 0, 0, "R3 device top");
    step(16'hD123, 1, 0, 0, 1, 0, "R3 device mid");
    step(16'h00FE, 0, 1, 1, 0, 0, "R4 port 254");
    step(16'h1234, 0, 1, 1, 0, 0, "R4 port lazy");
    step(16'h00FE, 0, 1, 0, 0, 0, "R4 port no rd");
    step(16'h00FE, 0, 1, 0, 1, 1, "R4 port write has no cs");
    step(16'hC000, 0, 1, 1, 0, 0, "R5 io at window addr");
    step(16'h0000, 0, 0, 0, 0, 0, "R8 idle");
    step(16'hC000, 1, 0, 1, 0, 0, "R6 still device before write");
    step(16'h00FF, 0, 1, 0, 1, 1, "R6 select write 1");
    step(16'hC000, 1, 0, 1, 0, 0, "R6 ram behind window");
    step(16'hFFFF, 0, 1, 1, 0, 0, "R5 io odd no cs");
    step(16'hC001, 1, 0, 0, 1, 0, "R9 mem write odd");
    step(16'hF000, 1, 0, 1, 0, 0, "R9 still ram in window");
    step(16'h00FF, 1, 1, 0, 1, 0, "R7 clash with select write");
    step(16'hC000, 1, 0, 1, 0, 0, "R7 clash write ignored");
    step(16'hC000, 1, 1, 1, 0, 0, "R7 clash window");
    step(16'h00FE, 1, 1, 1, 0, 0, "R7 clash port");
    step(16'h0001, 0, 1, 0, 1, 0, "R6 select write 0");
    step(16'hC000, 1, 0, 1, 0, 0, "R6 device restored");
    step(16'h2000, 1, 0, 1, 0, 0, "R10 ram single");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule